// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block steps a small microcontroller through five power modes: Normal, Idle, Suspend, Stop and Shutdown. Firmware requests a mode through write strobes to three control registers. These are a power-control register with an idle bit and a stop bit, an oscillator-control register with a suspend bit, and a regulator-control register that holds a shutdown arm bit. The controller then drives the core-clock enable, the peripheral-clock enable, the oscillator halt and the internal power-net shutdown. While a mode is active, the controller watches only the exit sources that belong to that mode.

Idle and Suspend wake without disturbing any state. Stop and Shutdown can only be left through a reset. On such an exit the controller returns to Normal, issues a one-cycle reset request to the reset generator (which restores the default 1.5 MHz clock setting) and clears the arm bit. The block is assumed to run from an always-on clock, so it keeps sequencing even while it reports the system oscillator as halted.

Top module: `pwr_mode_seq`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: mode is 0 (Normal), core and peripheral clock enables are 1, osc_halt and pwr_net_off are 0, rst_req is 0 and stop_arm is 0.
- R2: In Normal, a power-control write with the idle bit set enters Idle (mode code 1) at the next clock edge. In Idle the core clock enable is 0 and the peripheral clock enable stays 1.
- R3: Idle returns to Normal at the edge where irq_pend is high. USB activity and reset causes do not end Idle. This exit raises no rst_req and keeps stop_arm.
- R4: In Normal, an oscillator-control write with the suspend bit enters Suspend (mode code 2) when clk_sel equals 0, the internal 48 MHz oscillator. In Suspend both clock enables are 0 and osc_halt is 1.
- R5: A suspend write made while clk_sel is not 0 is ignored, and the mode stays Normal.
- R6: Suspend returns to Normal only at an edge where usb_act is high. irq_pend does not end it, and the exit raises no rst_req.
- R7: A stop write with stop_arm at 0 enters Stop (mode code 3), where both clock enables are 0 and osc_halt and pwr_net_off are 1. Any of rst_pin_evt, por_evt or oth_rst_evt returns the block to Normal. In the same edge, stop_arm clears and rst_req goes high for exactly one cycle.
- R8: A regulator-control write loads stop_arm from its data bit. A stop write with stop_arm at 1 enters Shutdown (mode code 4) with the same gating as Stop. vreg5_on follows vreg5_cfg. Only rst_pin_evt or por_evt ends Shutdown, and they do so with the rst_req pulse and arm clear of R7. oth_rst_evt is ignored.
- R9: If the exit condition of the requested mode is already high in the cycle of the entry write, the entry is cancelled and the mode stays Normal.
- R10: When requests coincide in one cycle, the stop bit wins over the suspend write, and the suspend write wins over the idle bit.
- R11: Control-register writes of any kind, including arm-bit writes, are ignored while the mode is not Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pcon_wr | input | 1 | Power-control register write strobe |
| pcon_idle | input | 1 | Idle request bit of the power-control write |
| pcon_stop | input | 1 | Stop request bit of the power-control write |
| osc_wr | input | 1 | Oscillator-control register write strobe |
| osc_suspend | input | 1 | Suspend request bit of the oscillator-control write |
| vreg_wr | input | 1 | Regulator-control register write strobe |
| vreg_stopcf | input | 1 | Shutdown arm data bit |
| vreg5_cfg | input | 1 | 5 V regulator enable setting |
| clk_sel | input | CLK_SEL_W | Current system-clock source, 0 = internal 48 MHz |
| irq_pend | input | 1 | Any interrupt pending |
| usb_act | input | 1 | USB bus activity detected |
| rst_pin_evt | input | 1 | Reset-pin event |
| por_evt | input | 1 | Power-on reset event |
| oth_rst_evt | input | 1 | Any other reset source |
| core_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_halt | output | 1 | Oscillator halt |
| pwr_net_off | output | 1 | Internal power-net shutdown |
| vreg5_on | output | 1 | 5 V regulator on |
| rst_req | output | 1 | One-cycle reset request on a reset-type exit |
| stop_arm | output | 1 | Shutdown arm bit |
| mode | output | 3 | Current mode code |

## Verification
The hardest situations to reach are the cancelled entries and the coinciding requests. A wake source must be high in exactly the cycle of an entry write, or several writes must land together. Directed steps build each one on purpose: idle with a pending interrupt, shutdown with a power-on event, and shutdown with a non-qualifying reset, which must still enter. Long random runs then use low-rate wake sources so that every mode is held for a while, and they mix coincident strobes under a bench model.

// File: rtl/pwr_mode_pkg.sv
// Shared mode codes and gate bundle for the power-mode sequencer.
// Assumes mode codes are fixed because software reads them.
package pwr_mode_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_NORM = 3'd0,
        M_IDLE = 3'd1,
        M_SUSP = 3'd2,
        M_STOP = 3'd3,
        M_SHDN = 3'd4
    } pmode_t;

    typedef struct packed {
        logic core_clk_en;
        logic per_clk_en;
        logic osc_halt;
        logic pwr_off;
    } gate_t;
endpackage

// File: rtl/pwr_wake_sel.sv
// Selects the exit condition that belongs to a given mode.
// Assumes wake and reset-cause inputs are already synchronous to clk.
module pwr_wake_sel
    import pwr_mode_pkg::*;
(
    input  pmode_t mode_i,
    input  logic   irq_pend,
    input  logic   usb_act,
    input  logic   rst_pin_evt,
    input  logic   por_evt,
    input  logic   oth_rst_evt,
    output logic   exit_now,
    output logic   exit_by_rst
);
    // Per-mode exit qualification.
    always_comb begin
        exit_now    = 1'b0;
        exit_by_rst = 1'b0;
        case (mode_i)
            M_IDLE: exit_now = irq_pend;
            M_SUSP: exit_now = usb_act;
            M_STOP: begin
                exit_now    = rst_pin_evt | por_evt | oth_rst_evt;
                exit_by_rst = 1'b1;
            end
            M_SHDN: begin
                exit_now    = rst_pin_evt | por_evt;
                exit_by_rst = 1'b1;
            end
            default: begin
                exit_now    = 1'b0;
                exit_by_rst = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pwr_req_decode.sv
// Decodes firmware writes into one requested mode, with priority
// stop > suspend > idle, and cancels it when its wake is already pending.
// Assumes it is only acted on while the current mode is Normal.
module pwr_req_decode
    import pwr_mode_pkg::*;
#(
    parameter int CLK_SEL_W  = 2,
    parameter int HFOSC_CODE = 0
) (
    input  logic                 pcon_wr,
    input  logic                 pcon_idle,
    input  logic                 pcon_stop,
    input  logic                 osc_wr,
    input  logic                 osc_suspend,
    input  logic [CLK_SEL_W-1:0] clk_sel,
    input  logic                 arm_q,
    input  logic                 irq_pend,
    input  logic                 usb_act,
    input  logic                 rst_pin_evt,
    input  logic                 por_evt,
    input  logic                 oth_rst_evt,
    output logic                 enter,
    output pmode_t               target
);
    localparam logic [CLK_SEL_W-1:0] HF_SEL = CLK_SEL_W'(HFOSC_CODE);

    logic   hf_ok;
    logic   want;
    pmode_t want_mode;
    logic   cancel;
    logic   cancel_rst;

    // Clock-source precondition for suspend.
    assign hf_ok = (clk_sel == HF_SEL);

    // Priority selection among simultaneous requests.
    always_comb begin
        want      = 1'b0;
        want_mode = M_NORM;
        if (pcon_wr && pcon_stop) begin
            want      = 1'b1;
            want_mode = arm_q ? M_SHDN : M_STOP;
        end else if (osc_wr && osc_suspend && hf_ok) begin
            want      = 1'b1;
            want_mode = M_SUSP;
        end else if (pcon_wr && pcon_idle) begin
            want      = 1'b1;
            want_mode = M_IDLE;
        end
    end

    // Wake already present for the requested mode cancels entry.
    pwr_wake_sel u_cancel (
        .mode_i      (want_mode),
        .irq_pend    (irq_pend),
        .usb_act     (usb_act),
        .rst_pin_evt (rst_pin_evt),
        .por_evt     (por_evt),
        .oth_rst_evt (oth_rst_evt),
        .exit_now    (cancel),
        .exit_by_rst (cancel_rst)
    );

    // Final entry decision.
    always_comb begin
        enter  = want & ~cancel;
        target = want_mode;
    end

    logic unused_ok;
    assign unused_ok = cancel_rst;
endmodule

// File: rtl/pwr_mode_fsm.sv
// Holds the current mode, the shutdown arm bit and the reset request.
// Assumes entry and exit decisions come from combinational decoders.
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enter,
    input  pmode_t target,
    input  logic   exit_now,
    input  logic   exit_by_rst,
    input  logic   vreg_wr,
    input  logic   vreg_stopcf,
    output pmode_t mode_q,
    output logic   arm_q,
    output logic   rst_req_q
);
    // Mode, arm and reset-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= M_NORM;
            arm_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (mode_q == M_NORM) begin
                if (enter) begin
                    mode_q <= target;
                end
                if (vreg_wr) begin
                    arm_q <= vreg_stopcf;
                end
            end else if (exit_now) begin
                mode_q <= M_NORM;
                if (exit_by_rst) begin
                    rst_req_q <= 1'b1;
                    arm_q     <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pwr_gate_map.sv
// Maps the current mode onto clock gates, oscillator halt and power nets.
// Assumes the 5 V regulator follows its setting in every mode.
module pwr_gate_map
    import pwr_mode_pkg::*;
(
    input  pmode_t mode_q,
    input  logic   vreg5_cfg,
    output gate_t  gates,
    output logic   vreg5_on
);
    // Gate pattern per mode.
    always_comb begin
        case (mode_q)
            M_NORM:  gates = '{core_clk_en: 1'b1, per_clk_en: 1'b1, osc_halt: 1'b0, pwr_off: 1'b0};
            M_IDLE:  gates = '{core_clk_en: 1'b0, per_clk_en: 1'b1, osc_halt: 1'b0, pwr_off: 1'b0};
            M_SUSP:  gates = '{core_clk_en: 1'b0, per_clk_en: 1'b0, osc_halt: 1'b1, pwr_off: 1'b0};
            M_STOP,
            M_SHDN:  gates = '{core_clk_en: 1'b0, per_clk_en: 1'b0, osc_halt: 1'b1, pwr_off: 1'b1};
            default: gates = '{core_clk_en: 1'b1, per_clk_en: 1'b1, osc_halt: 1'b0, pwr_off: 1'b0};
        endcase
    end

    // Regulator enable passthrough.
    assign vreg5_on = vreg5_cfg;
endmodule

// File: rtl/pwr_mode_seq.sv
// Top of the low-power mode sequencer: decodes requests, tracks the mode,
// qualifies exits and drives gating. Assumes all inputs are synchronous.
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int CLK_SEL_W  = 2,
    parameter int HFOSC_CODE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pcon_wr,
    input  logic                 pcon_idle,
    input  logic                 pcon_stop,
    input  logic                 osc_wr,
    input  logic                 osc_suspend,
    input  logic                 vreg_wr,
    input  logic                 vreg_stopcf,
    input  logic                 vreg5_cfg,
    input  logic [CLK_SEL_W-1:0] clk_sel,
    input  logic                 irq_pend,
    input  logic                 usb_act,
    input  logic                 rst_pin_evt,
    input  logic                 por_evt,
    input  logic                 oth_rst_evt,
    output logic                 core_clk_en,
    output logic                 per_clk_en,
    output logic                 osc_halt,
    output logic                 pwr_net_off,
    output logic                 vreg5_on,
    output logic                 rst_req,
    output logic                 stop_arm,
    output logic [MODE_W-1:0]    mode
);
    pmode_t mode_q;
    pmode_t target;
    logic   enter;
    logic   exit_now;
    logic   exit_by_rst;
    logic   arm_q;
    logic   rst_req_q;
    gate_t  gates;

    pwr_req_decode #(
        .CLK_SEL_W  (CLK_SEL_W),
        .HFOSC_CODE (HFOSC_CODE)
    ) u_dec (
        .pcon_wr     (pcon_wr),
        .pcon_idle   (pcon_idle),
        .pcon_stop   (pcon_stop),
        .osc_wr      (osc_wr),
        .osc_suspend (osc_suspend),
        .clk_sel     (clk_sel),
        .arm_q       (arm_q),
        .irq_pend    (irq_pend),
        .usb_act     (usb_act),
        .rst_pin_evt (rst_pin_evt),
        .por_evt     (por_evt),
        .oth_rst_evt (oth_rst_evt),
        .enter       (enter),
        .target      (target)
    );

    pwr_wake_sel u_wake (
        .mode_i      (mode_q),
        .irq_pend    (irq_pend),
        .usb_act     (usb_act),
        .rst_pin_evt (rst_pin_evt),
        .por_evt     (por_evt),
        .oth_rst_evt (oth_rst_evt),
        .exit_now    (exit_now),
        .exit_by_rst (exit_by_rst)
    );

    pwr_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter       (enter),
        .target      (target),
        .exit_now    (exit_now),
        .exit_by_rst (exit_by_rst),
        .vreg_wr     (vreg_wr),
        .vreg_stopcf (vreg_stopcf),
        .mode_q      (mode_q),
        .arm_q       (arm_q),
        .rst_req_q   (rst_req_q)
    );

    pwr_gate_map u_map (
        .mode_q    (mode_q),
        .vreg5_cfg (vreg5_cfg),
        .gates     (gates),
        .vreg5_on  (vreg5_on)
    );

    // Output assignment.
    assign core_clk_en = gates.core_clk_en;
    assign per_clk_en  = gates.per_clk_en;
    assign osc_halt    = gates.osc_halt;
    assign pwr_net_off = gates.pwr_off;
    assign rst_req     = rst_req_q;
    assign stop_arm    = arm_q;
    assign mode        = mode_q;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
// Checker for pwr_mode_seq: relates mode, gating and exits over time.
// Assumes it is bound to every instance of the top module.
module pwr_mode_seq_chk #(
    parameter int CLK_SEL_W  = 2,
    parameter int HFOSC_CODE = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pcon_wr,
    input logic                 osc_wr,
    input logic                 osc_suspend,
    input logic [CLK_SEL_W-1:0] clk_sel,
    input logic                 irq_pend,
    input logic                 usb_act,
    input logic                 rst_pin_evt,
    input logic                 por_evt,
    input logic                 oth_rst_evt,
    input logic                 core_clk_en,
    input logic                 per_clk_en,
    input logic                 osc_halt,
    input logic                 pwr_net_off,
    input logic                 rst_req,
    input logic                 stop_arm,
    input logic [2:0]           mode
);
    localparam logic [CLK_SEL_W-1:0] HF_SEL = CLK_SEL_W'(HFOSC_CODE);

    AST_IDLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |-> (!core_clk_en && per_clk_en)); // R2
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && irq_pend) |=> (mode == 3'd0 && !rst_req)); // R3
    AST_SUSP_NEEDS_HF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && osc_wr && osc_suspend && clk_sel != HF_SEL && !pcon_wr) |=> (mode == 3'd0)); // R5
    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && !usb_act) |=> (mode == 3'd2)); // R6
    AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && (rst_pin_evt || por_evt || oth_rst_evt)) |=> (mode == 3'd0 && rst_req)); // R7
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R7
    AST_RST_CLEARS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!stop_arm && mode == 3'd0)); // R7
    AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && !rst_pin_evt && !por_evt) |=> (mode == 3'd4)); // R8
    AST_DEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 || mode == 3'd4) |-> (!core_clk_en && !per_clk_en && osc_halt && pwr_net_off)); // R8
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(
    .CLK_SEL_W  (CLK_SEL_W),
    .HFOSC_CODE (HFOSC_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pcon_wr     (pcon_wr),
    .osc_wr      (osc_wr),
    .osc_suspend (osc_suspend),
    .clk_sel     (clk_sel),
    .irq_pend    (irq_pend),
    .usb_act     (usb_act),
    .rst_pin_evt (rst_pin_evt),
    .por_evt     (por_evt),
    .oth_rst_evt (oth_rst_evt),
    .core_clk_en (core_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_halt    (osc_halt),
    .pwr_net_off (pwr_net_off),
    .rst_req     (rst_req),
    .stop_arm    (stop_arm),
    .mode        (mode)
);

// File: tb/pwr_mode_seq_test.sv
// Bench for pwr_mode_seq: directed corner cases plus seeded random
// stimulus, each cycle compared against a bench-side mode model.
module pwr_mode_seq_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pcon_wr, pcon_idle, pcon_stop, osc_wr, osc_suspend;
    logic       vreg_wr, vreg_stopcf, vreg5_cfg;
    logic [1:0] clk_sel;
    logic       irq_pend, usb_act, rst_pin_evt, por_evt, oth_rst_evt;
    logic       core_clk_en, per_clk_en, osc_halt, pwr_net_off, vreg5_on, rst_req, stop_arm;
    logic [2:0] mode;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [2:0] m_mode;
    logic       m_arm;
    logic       m_rst;

    always #4 clk = ~clk;

    pwr_mode_seq uut (
        .clk(clk), .rst_n(rst_n), .pcon_wr(pcon_wr), .pcon_idle(pcon_idle),
        .pcon_stop(pcon_stop), .osc_wr(osc_wr), .osc_suspend(osc_suspend),
        .vreg_wr(vreg_wr), .vreg_stopcf(vreg_stopcf), .vreg5_cfg(vreg5_cfg),
        .clk_sel(clk_sel), .irq_pend(irq_pend), .usb_act(usb_act),
        .rst_pin_evt(rst_pin_evt), .por_evt(por_evt), .oth_rst_evt(oth_rst_evt),
        .core_clk_en(core_clk_en), .per_clk_en(per_clk_en), .osc_halt(osc_halt),
        .pwr_net_off(pwr_net_off), .vreg5_on(vreg5_on), .rst_req(rst_req),
        .stop_arm(stop_arm), .mode(mode)
    );

    // Expected output vector from model state and the R1..R8 gating rules.
    function automatic logic [9:0] exp_vec(input logic [2:0] md, input logic arm,
                                          input logic rq, input logic cfg);
        return {md, md == 3'd0, md <= 3'd1, md >= 3'd2, md >= 3'd3, cfg, rq, arm};
    endfunction

    // Model of one clock edge, written from the requirements.
    task automatic model_edge();
        logic       anyrst;
        logic       hardrst;
        logic [2:0] tgt;
        logic       want;
        logic       canc;
        anyrst  = rst_pin_evt | por_evt | oth_rst_evt;
        hardrst = rst_pin_evt | por_evt;
        if (!rst_n) begin
            m_mode = 3'd0; m_arm = 1'b0; m_rst = 1'b0;
            return;
        end
        m_rst = 1'b0;
        case (m_mode)
            3'd0: begin
                want = 1'b0; tgt = 3'd0; canc = 1'b0;
                if (pcon_wr && pcon_stop) begin
                    want = 1'b1; tgt = m_arm ? 3'd4 : 3'd3;
                    canc = m_arm ? hardrst : anyrst;
                end else if (osc_wr && osc_suspend && clk_sel == 2'd0) begin
                    want = 1'b1; tgt = 3'd2; canc = usb_act;
                end else if (pcon_wr && pcon_idle) begin
                    want = 1'b1; tgt = 3'd1; canc = irq_pend;
                end
                if (want && !canc) m_mode = tgt;
                if (vreg_wr) m_arm = vreg_stopcf;
            end
            3'd1: if (irq_pend) m_mode = 3'd0;
            3'd2: if (usb_act) m_mode = 3'd0;
            3'd3: if (anyrst) begin m_mode = 3'd0; m_rst = 1'b1; m_arm = 1'b0; end
            3'd4: if (hardrst) begin m_mode = 3'd0; m_rst = 1'b1; m_arm = 1'b0; end
            default: m_mode = 3'd0;
        endcase
    endtask

    task automatic clear_in();
        pcon_wr = 0; pcon_idle = 0; pcon_stop = 0; osc_wr = 0; osc_suspend = 0;
        vreg_wr = 0; vreg_stopcf = 0; irq_pend = 0; usb_act = 0;
        rst_pin_evt = 0; por_evt = 0; oth_rst_evt = 0;
    endtask

    // One edge: update model, then compare at the following falling edge.
    task automatic tick(input string tag);
        logic [9:0] act;
        logic [9:0] exp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        act = {mode, core_clk_en, per_clk_en, osc_halt, pwr_net_off, vreg5_on, rst_req, stop_arm};
        exp = exp_vec(m_mode, m_arm, m_rst, vreg5_cfg);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
        clear_in();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_mode = 3'd0; m_arm = 1'b0; m_rst = 1'b0;
        rst_n = 1'b0; vreg5_cfg = 1'b0; clk_sel = 2'd0;
        clear_in();
        @(negedge clk);
        tick("R1"); tick("R1");
        rst_n = 1'b1;
        tick("R1");
        // R2: idle entry and hold
        pcon_wr = 1; pcon_idle = 1; tick("R2");
        tick("R2");
        // R3: usb and other reset ignored in idle, interrupt wakes
        usb_act = 1; oth_rst_evt = 1; tick("R3");
        irq_pend = 1; tick("R3");
        // R5: suspend with wrong clock source ignored
        clk_sel = 2'd1; osc_wr = 1; osc_suspend = 1; tick("R5");
        clk_sel = 2'd2; osc_wr = 1; osc_suspend = 1; tick("R5");
        // R4: suspend with internal oscillator
        clk_sel = 2'd0; osc_wr = 1; osc_suspend = 1; tick("R4");
        // R6: interrupt ignored, usb wakes
        irq_pend = 1; tick("R6");
        usb_act = 1; tick("R6");
        // R9: idle entry cancelled by pending interrupt
        pcon_wr = 1; pcon_idle = 1; irq_pend = 1; tick("R9");
        // R9: suspend entry cancelled by usb activity
        osc_wr = 1; osc_suspend = 1; usb_act = 1; tick("R9");
        // R7: stop entry and reset exit
        pcon_wr = 1; pcon_stop = 1; tick("R7");
        irq_pend = 1; usb_act = 1; tick("R7");
        oth_rst_evt = 1; tick("R7");
        tick("R7");
        // R8: arm then stop gives shutdown
        vreg5_cfg = 1; vreg_wr = 1; vreg_stopcf = 1; tick("R8");
        pcon_wr = 1; pcon_stop = 1; tick("R8");
        oth_rst_evt = 1; tick("R8");
        vreg5_cfg = 0; tick("R8");
        rst_pin_evt = 1; tick("R8");
        tick("R8");
        // R11: writes ignored while idle
        pcon_wr = 1; pcon_idle = 1; tick("R11");
        vreg_wr = 1; vreg_stopcf = 1; tick("R11");
        pcon_wr = 1; pcon_stop = 1; osc_wr = 1; osc_suspend = 1; tick("R11");
        irq_pend = 1; tick("R11");
        // R10: stop wins over suspend and idle
        pcon_wr = 1; pcon_idle = 1; pcon_stop = 1; osc_wr = 1; osc_suspend = 1; tick("R10");
        por_evt = 1; tick("R10");
        // R10: suspend wins over idle
        pcon_wr = 1; pcon_idle = 1; osc_wr = 1; osc_suspend = 1; tick("R10");
        usb_act = 1; tick("R10");
        // R9: shutdown cancelled by power-on event, but not by other reset
        vreg_wr = 1; vreg_stopcf = 1; tick("R9");
        pcon_wr = 1; pcon_stop = 1; por_evt = 1; tick("R9");
        pcon_wr = 1; pcon_stop = 1; oth_rst_evt = 1; tick("R9");
        por_evt = 1; tick("R9");
        // R3: idle exit keeps the arm bit
        vreg_wr = 1; vreg_stopcf = 1; tick("R3");
        pcon_wr = 1; pcon_idle = 1; tick("R3");
        irq_pend = 1; tick("R3");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            pcon_wr     = ($urandom % 6) == 0;
            pcon_idle   = $urandom % 2;
            pcon_stop   = ($urandom % 3) == 0;
            osc_wr      = ($urandom % 6) == 0;
            osc_suspend = $urandom % 2;
            vreg_wr     = ($urandom % 10) == 0;
            vreg_stopcf = $urandom % 2;
            vreg5_cfg   = $urandom % 2;
            clk_sel     = (($urandom % 2) == 0) ? 2'd0 : 2'($urandom % 4);
            irq_pend    = ($urandom % 10) == 0;
            usb_act     = ($urandom % 10) == 0;
            rst_pin_evt = ($urandom % 30) == 0;
            por_evt     = ($urandom % 40) == 0;
            oth_rst_evt = ($urandom % 15) == 0;
            tick("RND");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule